// File: doc/BRIEF.md
# Byte-Framed Serial Peripheral Slave

This block is the target end of a four-wire serial peripheral link. It moves one 8-bit word each way per transfer, most significant bit first. A processor loads the word to send through a write port and collects the received word through a read port. Status flags report a waiting received byte, a lost byte and an empty transmit holding register, and an interrupt request follows the receive flag.

All bus inputs are oversampled into the system clock through two-stage synchronisers. Clock edges are found in that domain, so the system clock must run at least four times faster than the serial clock. A polarity input sets the idle level of the serial clock. A phase input picks one of two framings.

In phase 0 the first data bit is put on the line as soon as select falls, and each select assertion frames exactly one byte. Any further clocks in the same select return zeros and are not received. A transmit write made while selected is discarded for good. In phase 1 data is driven on the leading edge and sampled on the trailing edge. Bytes may follow back to back inside one select, and each byte takes whatever the holding register contains when it starts.

Top module: `spis_top`

## Requirements
- R1: After reset, tx_empty is 1; rx_full, overrun, irq and miso_oe are 0.
- R2: Transfers are 8 bits, MSB first in both directions. A byte written while deselected, before the first select, is returned to the master on the first transfer.
- R3: With cpha=0 and select low, a transmit write is discarded. It leaves tx_empty and the holding register unchanged, and the discarded byte is never sent, including on later selects.
- R4: With cpha=0, only the first byte after a select falling edge is received. Further bytes in the same select are shifted out as 0x00, and rx_full and rx_data are left unchanged.
- R5: On completion of each received byte, rx_full is set and irq is raised. irq equals rx_full.
- R6: With cpha=1, several bytes may be transferred inside one select. Each byte loads the holding register at its first leading edge, and writes made while selected are accepted.
- R7: A leading edge moves the serial clock away from its idle level, which is given by cpol. With cpha=0, bits are sampled on leading edges and shifted on trailing edges. With cpha=1, bits are driven on leading edges and sampled on trailing edges. Both polarities give the same data.
- R8: While select is high, miso_oe is 0 and the bit counter is held at zero. While select is low, miso_oe is 1.
- R9: A read pulse on rx_rd clears rx_full and overrun. A byte that completes while rx_full is still set replaces rx_data and sets overrun.
- R10: tx_empty is set when the holding register is loaded into the shifter. An accepted write clears it.
- R11: A byte whose load happens with tx_empty set is shifted out as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | Framing phase select (0 or 1) |
| sck_in | input | 1 | Serial clock from master |
| mosi_in | input | 1 | Serial data from master |
| sel_n_in | input | 1 | Active-low select from master |
| miso_out | output | 1 | Serial data to master |
| miso_oe | output | 1 | Drive enable for miso_out |
| tx_wr | input | 1 | Transmit write strobe |
| tx_data | input | 8 | Transmit write data |
| tx_empty | output | 1 | Holding register has been taken by the shifter |
| rx_rd | input | 1 | Received data read strobe |
| rx_data | output | 8 | Last received byte |
| rx_full | output | 1 | Unread received byte present |
| overrun | output | 1 | A byte arrived while rx_full was set |
| irq | output | 1 | Receive interrupt request |

## Verification
The assertions check these rules on every cycle: the drive enable stays off while deselected, a blocked phase-0 write leaves the holding register untouched, no second byte completes inside one phase-0 select, and the receive flag, interrupt, overrun and transmit-empty flags update correctly around completion, read, load and write events. Only the bench scenarios can show the data itself. Those cover MSB-first content under both phases and both polarities, the discarded byte never reappearing on a later select, the zero bytes after the first in phase 0, and streaming with host service between bytes in phase 1.

// File: rtl/spis_pkg.sv
// Shared types for the serial slave.
// Assumes: nothing beyond the definitions below.
package spis_pkg;

    // Framing phase: where a bit is sampled relative to the leading edge.
    typedef enum logic {
        PH_SAMPLE_LEAD = 1'b0,
        PH_DRIVE_LEAD  = 1'b1
    } phase_e;

    // Bus input bundle in synchroniser order.
    typedef struct packed {
        logic sel_n;
        logic sck;
        logic mosi;
    } bus_t;

endpackage

// File: rtl/spis_sync.sv
// Multi-stage synchroniser, one independent flop chain per input bit.
// Assumes: STAGES >= 2; inputs are asynchronous single bits.
module spis_sync #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [STAGES-1:0] chain;

        // Shift the raw bit through the flop chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[i]}};
            else        chain <= {chain[STAGES-2:0], d[i]};
        end

        assign q[i] = chain[STAGES-1];
    end

endmodule

// File: rtl/spis_shift.sv
// Bus-side shift engine. It detects serial clock edges in the system clock
// domain, shifts data in and out, and frames bytes by phase.
// Assumes: synchronised inputs, system clock >= 4x serial clock, and phase
// held constant while selected.
module spis_shift
    import spis_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpol,
    input  phase_e            phase,
    input  logic              sel_n_s,
    input  logic              sck_s,
    input  logic              mosi_s,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              tx_valid,
    output logic              load_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rx_word_o,
    output logic              miso_o,
    output logic              oe_o
);

    localparam int             CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    logic              sck_q, sel_q;
    logic              active, sel_fall, lead, trail;
    logic              sample, shift, load, done;
    logic              locked;
    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] tx_sh, rx_sh, rx_next, fill;

    // Keep one-cycle history of clock and select for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            sel_q <= 1'b1;
        end else begin
            sck_q <= sck_s;
            sel_q <= sel_n_s;
        end
    end

    // Decode edges and the per-phase shift, sample and load events.
    always_comb begin
        active   = !sel_n_s;
        sel_fall = sel_q && !sel_n_s;
        lead     = active && (sck_q == cpol) && (sck_s != cpol);
        trail    = active && (sck_q != cpol) && (sck_s == cpol);
        rx_next  = {rx_sh[DATA_W-2:0], mosi_s};
        fill     = tx_valid ? tx_word : '0;
        if (phase == PH_SAMPLE_LEAD) begin
            load   = sel_fall;
            sample = lead && !locked;
            shift  = trail && !locked;
        end else begin
            load   = lead && (bit_cnt == '0);
            sample = trail;
            shift  = lead && (bit_cnt != '0);
        end
        done = sample && (bit_cnt == LAST);
    end

    // Run the shifters and bit counter; hold the counter at zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh   <= '0;
            rx_sh   <= '0;
            bit_cnt <= '0;
            locked  <= 1'b0;
        end else if (!active) begin
            bit_cnt <= '0;
            locked  <= 1'b0;
        end else begin
            if (load)
                tx_sh <= fill;
            else if (done && phase == PH_SAMPLE_LEAD)
                tx_sh <= '0;
            else if (shift)
                tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
            if (sample) begin
                rx_sh   <= rx_next;
                bit_cnt <= done ? '0 : bit_cnt + 1'b1;
            end
            if (done && phase == PH_SAMPLE_LEAD)
                locked <= 1'b1;
        end
    end

    // Register the output enable from the synchronised select.
    always_ff @(posedge clk) begin
        if (!rst_n) oe_o <= 1'b0;
        else        oe_o <= active;
    end

    assign load_o    = load;
    assign done_o    = done;
    assign rx_word_o = rx_next;
    assign miso_o    = tx_sh[DATA_W-1];

endmodule

// File: rtl/spis_regs.sv
// Processor-side registers: transmit holding register with an empty flag,
// and a receive register with full and overrun flags.
// Assumes: strobes are single-cycle and synchronous to clk.
module spis_regs #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_allow,
    input  logic              rd,
    input  logic              load,
    input  logic              done,
    input  logic [DATA_W-1:0] rx_word,
    output logic              accept,
    output logic [DATA_W-1:0] txd,
    output logic              tx_empty,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              overrun
);

    assign accept = wr && wr_allow;

    // Capture accepted writes; mark the register empty when the shifter loads it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txd      <= '0;
            tx_empty <= 1'b1;
        end else if (accept) begin
            txd      <= wr_data;
            tx_empty <= 1'b0;
        end else if (load) begin
            tx_empty <= 1'b1;
        end
    end

    // Store completed bytes and keep the full and overrun flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data <= '0;
            rx_full <= 1'b0;
            overrun <= 1'b0;
        end else if (done) begin
            rx_data <= rx_word;
            rx_full <= 1'b1;
            overrun <= rd ? 1'b0 : (overrun || rx_full);
        end else if (rd) begin
            rx_full <= 1'b0;
            overrun <= 1'b0;
        end
    end

endmodule

// File: rtl/spis_top.sv
// Serial peripheral slave top. It synchronises the bus inputs, runs the
// shift engine and exposes the processor-side registers. Phase-0 writes are
// blocked while the synchronised select is low.
// Assumes: system clock >= 4x serial clock; cpol/cpha are changed only while
// deselected.
module spis_top
    import spis_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              sck_in,
    input  logic              mosi_in,
    input  logic              sel_n_in,
    output logic              miso_out,
    output logic              miso_oe,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_empty,
    input  logic              rx_rd,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              overrun,
    output logic              irq
);

    localparam int BUS_W = $bits(bus_t);

    bus_t              bus_raw, bus_s;
    phase_e            phase;
    logic              sel_n_s;
    logic              load_pulse, byte_done, tx_accept, wr_allow;
    logic [DATA_W-1:0] rx_word, txd_q;

    assign bus_raw = '{sel_n: sel_n_in, sck: sck_in, mosi: mosi_in};
    assign phase   = phase_e'(cpha);
    assign sel_n_s = bus_s.sel_n;

    spis_sync #(
        .WIDTH   (BUS_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (BUS_W'(3'b100))
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (bus_raw),
        .q     (bus_s)
    );

    spis_shift #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpol      (cpol),
        .phase     (phase),
        .sel_n_s   (sel_n_s),
        .sck_s     (bus_s.sck),
        .mosi_s    (bus_s.mosi),
        .tx_word   (txd_q),
        .tx_valid  (!tx_empty),
        .load_o    (load_pulse),
        .done_o    (byte_done),
        .rx_word_o (rx_word),
        .miso_o    (miso_out),
        .oe_o      (miso_oe)
    );

    // Phase 0 locks out transmit writes for the whole select window.
    assign wr_allow = !(phase == PH_SAMPLE_LEAD && !sel_n_s);

    spis_regs #(.DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (tx_wr),
        .wr_data  (tx_data),
        .wr_allow (wr_allow),
        .rd       (rx_rd),
        .load     (load_pulse),
        .done     (byte_done),
        .rx_word  (rx_word),
        .accept   (tx_accept),
        .txd      (txd_q),
        .tx_empty (tx_empty),
        .rx_data  (rx_data),
        .rx_full  (rx_full),
        .overrun  (overrun)
    );

    assign irq = rx_full;

endmodule

// File: rtl/spis_chk.sv
// Cycle-level rule checker for spis_top, attached by bind.
// Assumes: cpha is constant while select is low.
module spis_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpha,
    input logic              sel_n_s,
    input logic              miso_oe,
    input logic              byte_done,
    input logic              load_pulse,
    input logic              tx_accept,
    input logic              tx_wr,
    input logic [DATA_W-1:0] txd_q,
    input logic              tx_empty,
    input logic              rx_rd,
    input logic              rx_full,
    input logic              irq,
    input logic              overrun
);

    logic [1:0] done_seen;

    // Count completed bytes inside the current select window.
    always_ff @(posedge clk) begin
        if (!rst_n || sel_n_s)                    done_seen <= 2'd0;
        else if (byte_done && done_seen != 2'd3) done_seen <= done_seen + 2'd1;
    end

    // R8
    oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n_s |=> !miso_oe);

    // R3
    drop_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && !cpha && !sel_n_s) |=> ($stable(txd_q) && $stable(tx_empty)));

    // R4
    single_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpha && done_seen != 2'd0) |-> !byte_done);

    // R5
    rx_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> (rx_full && irq));

    // R9
    overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && rx_full && !rx_rd) |=> overrun);

    // R9
    rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd && !byte_done) |=> (!rx_full && !overrun));

    // R10
    tx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_pulse && !tx_accept) |=> tx_empty);

    // R10
    tx_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_accept |=> !tx_empty);

endmodule

bind spis_top spis_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpha       (cpha),
    .sel_n_s    (sel_n_s),
    .miso_oe    (miso_oe),
    .byte_done  (byte_done),
    .load_pulse (load_pulse),
    .tx_accept  (tx_accept),
    .tx_wr      (tx_wr),
    .txd_q      (txd_q),
    .tx_empty   (tx_empty),
    .rx_rd      (rx_rd),
    .rx_full    (rx_full),
    .irq        (irq),
    .overrun    (overrun)
);

// File: tb/spis_top_test.sv
`timescale 1ns/1ps
module spis_top_test;

    localparam int H = 6;          // system clocks per serial half period
    localparam int WATCHDOG = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpol = 1'b0, cpha = 1'b0;
    logic       sck_in = 1'b0, mosi_in = 1'b0, sel_n_in = 1'b1;
    logic       miso_out, miso_oe;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_empty;
    logic       rx_rd = 1'b0;
    logic [7:0] rx_data;
    logic       rx_full, overrun, irq;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    spis_top uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpol     (cpol),
        .cpha     (cpha),
        .sck_in   (sck_in),
        .mosi_in  (mosi_in),
        .sel_n_in (sel_n_in),
        .miso_out (miso_out),
        .miso_oe  (miso_oe),
        .tx_wr    (tx_wr),
        .tx_data  (tx_data),
        .tx_empty (tx_empty),
        .rx_rd    (rx_rd),
        .rx_data  (rx_data),
        .rx_full  (rx_full),
        .overrun  (overrun),
        .irq      (irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sel_on();
        sel_n_in = 1'b0;
        tick(H);
    endtask

    task automatic sel_off();
        tick(H);
        sel_n_in = 1'b1;
        tick(H);
    endtask

    task automatic set_mode(input logic pol, input logic pha);
        cpol = pol;
        cpha = pha;
        sck_in = pol;
        tick(H);
    endtask

    task automatic host_write(input logic [7:0] d);
        tx_data = d;
        tx_wr = 1'b1;
        tick(1);
        tx_wr = 1'b0;
        tick(1);
    endtask

    task automatic host_read(output logic [7:0] d);
        d = rx_data;
        rx_rd = 1'b1;
        tick(1);
        rx_rd = 1'b0;
        tick(1);
    endtask

    // One byte as master, MSB first, in the current mode.
    task automatic xfer(input logic [7:0] mo, output logic [7:0] mi);
        for (int b = 7; b >= 0; b--) begin
            if (!cpha) begin
                mosi_in = mo[b];
                tick(H);
                mi[b] = miso_out;
                sck_in = ~cpol;
                tick(H);
                sck_in = cpol;
            end else begin
                sck_in = ~cpol;
                mosi_in = mo[b];
                tick(H);
                mi[b] = miso_out;
                sck_in = cpol;
                tick(H);
            end
        end
        tick(H);
    endtask

    task automatic t_reset();
        check("R1 tx_empty", {7'd0, tx_empty}, 8'h01);
        check("R1 rx_full", {7'd0, rx_full}, 8'h00);
        check("R1 overrun", {7'd0, overrun}, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);
        check("R1 miso_oe", {7'd0, miso_oe}, 8'h00);
    endtask

    task automatic t_preload();
        logic [7:0] mi, r;
        set_mode(1'b0, 1'b0);
        host_write(8'hA5);
        check("R10 write clears tx_empty", {7'd0, tx_empty}, 8'h00);
        sel_on();
        check("R8 oe while selected", {7'd0, miso_oe}, 8'h01);
        check("R10 load sets tx_empty", {7'd0, tx_empty}, 8'h01);
        xfer(8'h3C, mi);
        check("R2 preload sent", mi, 8'hA5);
        check("R5 rx_full", {7'd0, rx_full}, 8'h01);
        check("R5 irq", {7'd0, irq}, 8'h01);
        check("R2 rx_data", rx_data, 8'h3C);
        sel_off();
        check("R8 oe idle", {7'd0, miso_oe}, 8'h00);
        host_read(r);
        check("R9 read clears rx_full", {7'd0, rx_full}, 8'h00);
    endtask

    task automatic t_drop();
        logic [7:0] mi, r;
        set_mode(1'b0, 1'b0);
        sel_on();
        host_write(8'h55);
        check("R3 blocked write keeps tx_empty", {7'd0, tx_empty}, 8'h01);
        xfer(8'h01, mi);
        check("R11 empty load sends zero", mi, 8'h00);
        sel_off();
        host_read(r);
        check("R7 phase0 rx_data", r, 8'h01);
        sel_on();
        xfer(8'h02, mi);
        check("R3 dropped byte never sent", mi, 8'h00);
        sel_off();
        host_read(r);
    endtask

    task automatic t_one_per_select();
        logic [7:0] mi, r;
        set_mode(1'b0, 1'b0);
        host_write(8'h81);
        sel_on();
        xfer(8'h5A, mi);
        check("R4 first byte out", mi, 8'h81);
        host_read(r);
        check("R4 first byte in", r, 8'h5A);
        xfer(8'hC3, mi);
        check("R4 second byte zeros", mi, 8'h00);
        check("R4 second byte not received", {7'd0, rx_full}, 8'h00);
        check("R4 rx_data unchanged", rx_data, 8'h5A);
        sel_off();
    endtask

    task automatic t_stream();
        logic [7:0] mi, r;
        set_mode(1'b0, 1'b1);
        host_write(8'hB1);
        sel_on();
        xfer(8'h11, mi);
        check("R6 stream byte 1 out", mi, 8'hB1);
        host_read(r);
        check("R6 stream byte 1 in", r, 8'h11);
        host_write(8'hC2);
        check("R6 write accepted while selected", {7'd0, tx_empty}, 8'h00);
        xfer(8'h22, mi);
        check("R6 stream byte 2 out", mi, 8'hC2);
        check("R6 stream byte 2 in", rx_data, 8'h22);
        sel_off();
        host_read(r);
    endtask

    task automatic t_overrun();
        logic [7:0] mi, r;
        set_mode(1'b0, 1'b1);
        host_write(8'h11);
        sel_on();
        xfer(8'hE1, mi);
        check("R7 phase1 out", mi, 8'h11);
        xfer(8'h7E, mi);
        check("R11 phase1 empty sends zero", mi, 8'h00);
        check("R9 overrun set", {7'd0, overrun}, 8'h01);
        check("R9 newest data kept", rx_data, 8'h7E);
        sel_off();
        host_read(r);
        check("R9 read clears overrun", {7'd0, overrun}, 8'h00);
    endtask

    task automatic t_polarity();
        logic [7:0] mi, r;
        set_mode(1'b1, 1'b0);
        host_write(8'h96);
        sel_on();
        xfer(8'h69, mi);
        check("R7 cpol1 phase0 out", mi, 8'h96);
        check("R7 cpol1 phase0 in", rx_data, 8'h69);
        sel_off();
        host_read(r);
        set_mode(1'b1, 1'b1);
        host_write(8'h4D);
        sel_on();
        xfer(8'hB2, mi);
        check("R7 cpol1 phase1 out", mi, 8'h4D);
        check("R7 cpol1 phase1 in", rx_data, 8'hB2);
        sel_off();
        host_read(r);
    endtask

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(4);
        t_reset();
        t_preload();
        t_drop();
        t_one_per_select();
        t_stream();
        t_overrun();
        t_polarity();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule